// File: doc/BRIEF.md
# FFT Butterfly Index Schedule Generator

This block is a sequencer for an in-place radix-2 transform over N points, where N is a power of two set at run time. Each emitted step names one butterfly: a low element index, a high element index and a twiddle table index. The steps come in stage order. Inside a stage they come in group order, and inside a group they come in pair order. A datapath elsewhere reads both elements and the twiddle at those indices, combines them, and writes the two results back to the same locations. The block does not permute any address. The data must already be in bit-reversed order before the schedule starts.

The block has two modes, and the mode is captured when the schedule starts. In free-running mode it emits one step every cycle. In single-step mode it emits one step for each cycle in which the step request is high. This lets a software-style loop drive every iteration explicitly. The final step carries a `last` flag. After the final step, `done` stays high until the next start, which gives the controlling loop its exit condition. The indices are a plain registered output qualified by `valid`. There is no back-pressure path: a consumer that needs time to process a step should use single-step mode and hold off its step requests.

Top module: `bfly_sched_top`

## Requirements
- R1: After reset, `valid`, `last` and `done` are low, and they stay low until a start is accepted.
- R2: For size N = 2^L, stage s (from 0 to L-1) uses half-span h = 2^s and span 2h. Groups start at base 0, 2h, 4h and so on up to N-2h. Inside a group the pair offset p runs from 0 to h-1. Each step outputs `jl` = base+p and `jh` = base+p+h, in stage, then group, then pair order.
- R3: The twiddle index `tw` equals p·(N/2h). It is therefore 0 at the first pair of every group and grows by N/2h for each following pair.
- R4: In free-running mode (`single_step`=0 at start), the first step is valid in the second cycle after the start is sampled. After that, steps are valid on consecutive cycles, and there are exactly (N/2)·L of them in total.
- R5: In single-step mode (`single_step`=1 at start), a step is emitted, valid in the next cycle, only when `step_en` is high in a cycle of a running schedule. `valid` is low in every other cycle.
- R6: `last` is high together with `valid` on the final step of the schedule, and at no other time.
- R7: `done` rises one cycle after the final step is presented. It stays high, with `valid` low, until a start is accepted, and it drops in the cycle after that start.
- R8: A `start` pulse arriving while a schedule is running is ignored. The running sequence continues unchanged.
- R9: `log2n` and `single_step` are sampled only when a start is accepted. A `log2n` value of 0 is treated as 1, and a value above MAX_LOG2 is treated as MAX_LOG2.
- R10: `step_en` has no effect while no schedule is running, either before the first start or after the schedule finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a schedule; accepted only when none is running |
| single_step | input | 1 | Mode sampled at start: 0 free-running, 1 one step per request |
| step_en | input | 1 | Step request in single-step mode |
| log2n | input | LOG_W (3) | Transform size as log2 N, sampled at start |
| jl | output | IDX_W (6) | Low element index of the current butterfly |
| jh | output | IDX_W (6) | High element index of the current butterfly |
| tw | output | IDX_W (6) | Twiddle table index of the current butterfly |
| valid | output | 1 | The index outputs hold a step this cycle |
| last | output | 1 | The current step is the final one |
| done | output | 1 | Schedule complete; held until the next start |

## Verification
The bench builds the block with its default MAX_LOG2 of 6. At that size every legal transform size, from 2 to 64 points, can be swept in free-running mode, and every emitted index triple can be compared against a schedule computed in the bench, which comes to 321 steps in total. Single-step mode is exercised at 8 points, with idle gaps between requests and a start pulse injected mid-run. The clamped sizes 0 and 7 are driven as well, which exercises both ends of the size range, including the largest 192-step schedule.

// File: rtl/bfly_sched_pkg.sv
package bfly_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } run_state_e;
endpackage

// File: rtl/bfly_stage_walk.sv
// Holds the stage, group base and pair offset of the next butterfly to issue
// and steps them in stage, group, pair order.
module bfly_stage_walk #(
  parameter int IDX_W = 6,
  parameter int LOG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [LOG_W-1:0] ln,
  output logic [LOG_W-1:0] stage,
  output logic [IDX_W-1:0] base,
  output logic [IDX_W-1:0] offs,
  output logic             is_last
);
  logic [IDX_W:0] half_w, span_w, n_w, grp_next;
  logic           pair_end, grp_end, stage_end;

  always_comb begin
    half_w    = (IDX_W+1)'(1) << stage;
    span_w    = half_w << 1;
    n_w       = (IDX_W+1)'(1) << ln;
    grp_next  = {1'b0, base} + span_w;
    pair_end  = ({1'b0, offs} + (IDX_W+1)'(1)) == half_w;
    grp_end   = grp_next == n_w;
    stage_end = stage == (ln - LOG_W'(1));
    is_last   = pair_end && grp_end && stage_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      base  <= '0;
      offs  <= '0;
    end else if (clear) begin
      stage <= '0;
      base  <= '0;
      offs  <= '0;
    end else if (advance) begin
      if (!pair_end) begin
        offs <= offs + IDX_W'(1);
      end else begin
        offs <= '0;
        if (grp_end) begin
          base  <= '0;
          stage <= stage + LOG_W'(1);
        end else begin
          base <= grp_next[IDX_W-1:0];
        end
      end
    end
  end

  // R2: the pair offset never leaves the current half-span
  a_r2_offs_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> ({1'b0, offs} < half_w));

  // R2: group bases stay aligned to the span
  a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (({1'b0, base} & (span_w - (IDX_W+1)'(1))) == '0));
endmodule

// File: rtl/bfly_index_map.sv
// Turns the walk position into element and twiddle indices.
module bfly_index_map #(
  parameter int IDX_W = 6,
  parameter int LOG_W = 3
) (
  input  logic [LOG_W-1:0] ln,
  input  logic [LOG_W-1:0] stage,
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] offs,
  output logic [IDX_W-1:0] idx_lo,
  output logic [IDX_W-1:0] idx_hi,
  output logic [IDX_W-1:0] idx_tw
);
  logic [IDX_W:0]   half_w;
  logic [LOG_W-1:0] tw_shift;

  always_comb begin
    half_w   = (IDX_W+1)'(1) << stage;
    tw_shift = ln - LOG_W'(1) - stage;
    idx_lo   = base + offs;
    idx_hi   = idx_lo + half_w[IDX_W-1:0];
    idx_tw   = offs << tw_shift;
  end
endmodule

// File: rtl/bfly_sched_top.sv
module bfly_sched_top
  import bfly_sched_pkg::*;
#(
  parameter int MAX_LOG2 = 6,
  localparam int IDX_W = MAX_LOG2,
  localparam int LOG_W = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             single_step,
  input  logic             step_en,
  input  logic [LOG_W-1:0] log2n,
  output logic [IDX_W-1:0] jl,
  output logic [IDX_W-1:0] jh,
  output logic [IDX_W-1:0] tw,
  output logic             valid,
  output logic             last,
  output logic             done
);
  run_state_e       state;
  logic [LOG_W-1:0] ln_q, ln_clamped;
  logic             mode_q;
  logic             accept_start, emit, is_last;
  logic [LOG_W-1:0] stage;
  logic [IDX_W-1:0] base, offs;
  logic [IDX_W-1:0] idx_lo, idx_hi, idx_tw;

  always_comb begin
    if (log2n == '0)                         ln_clamped = LOG_W'(1);
    else if (log2n > LOG_W'(MAX_LOG2))       ln_clamped = LOG_W'(MAX_LOG2);
    else                                     ln_clamped = log2n;
    accept_start = start && (state != ST_RUN);
    emit         = (state == ST_RUN) && (!mode_q || step_en);
  end

  bfly_stage_walk #(.IDX_W(IDX_W), .LOG_W(LOG_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .clear(accept_start), .advance(emit),
    .ln(ln_q), .stage(stage), .base(base), .offs(offs), .is_last(is_last)
  );

  bfly_index_map #(.IDX_W(IDX_W), .LOG_W(LOG_W)) map_i (
    .ln(ln_q), .stage(stage), .base(base), .offs(offs),
    .idx_lo(idx_lo), .idx_hi(idx_hi), .idx_tw(idx_tw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ln_q   <= LOG_W'(1);
      mode_q <= 1'b0;
    end else if (accept_start) begin
      state  <= ST_RUN;
      ln_q   <= ln_clamped;
      mode_q <= single_step;
    end else if (emit && is_last) begin
      state  <= ST_FIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jl    <= '0;
      jh    <= '0;
      tw    <= '0;
      valid <= 1'b0;
      last  <= 1'b0;
      done  <= 1'b0;
    end else begin
      valid <= emit;
      last  <= emit && is_last;
      done  <= (state == ST_FIN) && !start;
      if (emit) begin
        jl <= idx_lo;
        jh <= idx_hi;
        tw <= idx_tw;
      end
    end
  end

  // R5: in single-step mode every emitted step was requested the cycle before
  a_r5_step_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_q) |-> $past(step_en));

  // R6: last only accompanies a valid step
  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  // R7: done holds until a start arrives
  a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7: no step is presented while done
  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);

  // R8: a start during a run does not leave the running state early
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_RUN && !(emit && is_last)) |=> (state == ST_RUN));

  // R2: the high index lies above the low index
  a_r2_hi_above_lo: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (jh > jl));

  // R3: twiddle index stays below N/2
  a_r3_tw_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ({1'b0, tw} < ((IDX_W+1)'(1) << (ln_q - LOG_W'(1)))));
endmodule

// File: tb/bfly_sched_top_tb_top.sv
module bfly_sched_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 6;
  localparam int IW = 6;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          single_step = 1'b0;
  logic          step_en = 1'b0;
  logic [LW-1:0] log2n = '0;
  logic [IW-1:0] jl, jh, tw;
  logic          valid, last, done;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfly_sched_top #(.MAX_LOG2(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .single_step(single_step),
    .step_en(step_en), .log2n(log2n), .jl(jl), .jh(jh), .tw(tw),
    .valid(valid), .last(last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare one presented step against its expected indices
  task automatic chk_step(input int ejl, input int ejh, input int etw, input bit elast);
    chk(valid == 1'b1, "R4/R5 valid", int'(valid), 1);
    chk(int'(jl) == ejl, "R2 jl", int'(jl), ejl);
    chk(int'(jh) == ejh, "R2 jh", int'(jh), ejh);
    chk(int'(tw) == etw, "R3 tw", int'(tw), etw);
    chk(last == elast, "R6 last", int'(last), int'(elast));
  endtask

  // free-running run; inp is driven on log2n, L is the effective size (R9)
  task automatic run_free(input int inp, input int L, input int ign_at);
    int n = 1 << L;
    int idx = 0;
    int tot = (n / 2) * L;
    @(negedge clk);
    log2n = LW'(inp);
    single_step = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    log2n = LW'(MAXL - L + 1);
    chk(valid == 1'b0, "R4 no step in first cycle", int'(valid), 0);
    chk(done == 1'b0, "R7 done cleared by start", int'(done), 0);
    for (int s = 0; s < L; s++) begin
      for (int g = 0; g < n; g += (2 << s)) begin
        for (int p = 0; p < (1 << s); p++) begin
          @(negedge clk);
          chk_step(g + p, g + p + (1 << s), p * (n / (2 << s)), idx == tot - 1);
          start = (idx == ign_at); // R8 start injected mid-run
          idx++;
        end
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b0, "R4 step count", int'(valid), 0);
    chk(done == 1'b1, "R7 done after last", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(last == 1'b0, "R1 last", int'(last), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    // R10 step requests with no schedule
    step_en = 1'b1;
    repeat (3) @(negedge clk);
    step_en = 1'b0;
    chk(valid == 1'b0 && done == 1'b0, "R10 idle step_en", int'(valid), 0);

    // R2 R3 R4 sweep every size, with an R8 start injected in size 16
    for (int L = 1; L <= MAXL; L++) run_free(L, L, (L == 4) ? 5 : -1);

    // R7 done held over idle cycles
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R7 done held", int'(done), 1);
    // R10 step_en after completion
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0 && done == 1'b1, "R10 step_en after done", int'(valid), 0);

    // R9 clamp of out-of-range sizes
    run_free(0, 1, -1);
    run_free(7, MAXL, -1);

    // R5 single-step mode at N=8, with gaps and an R8 start mid-run
    begin
      int idx = 0;
      @(negedge clk);
      log2n = LW'(3);
      single_step = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      single_step = 1'b0; // R9: mode already captured
      log2n = LW'(5);
      for (int s = 0; s < 3; s++) begin
        for (int g = 0; g < 8; g += (2 << s)) begin
          for (int p = 0; p < (1 << s); p++) begin
            start = (idx == 4);
            repeat (2) begin
              @(negedge clk);
              start = 1'b0;
              chk(valid == 1'b0, "R5 no step without request", int'(valid), 0);
            end
            step_en = 1'b1;
            @(negedge clk);
            step_en = 1'b0;
            chk_step(g + p, g + p + (1 << s), p * (8 / (2 << s)), idx == 11);
            idx++;
          end
        end
      end
      @(negedge clk);
      chk(valid == 1'b0, "R5 twelve steps only", int'(valid), 0);
      chk(done == 1'b1, "R7 done in single-step", int'(done), 1);
    end

    // R7 done drops after a new start
    @(negedge clk);
    log2n = LW'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7 done cleared", int'(done), 1'b0);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule